// File: doc/BRIEF.md
# Multi-Mode 16-bit Down-Counting Timer

This block is a 16-bit down-counter with a fixed-ratio prescaler and one output line. The clock comes from one of eight external enable sources. A control word turns the timer on and off and picks one of four output behaviours. The same word sets the output polarity and chooses between push-pull and open-drain drive. A separate register holds the reload value.

The four behaviours are a single pulse, a rate generator, a square wave, and a one-shot that an external input can restart. Each time the counter reaches zero it raises a sticky interrupt flag. Software clears the flag by pulsing a clear input. The current count is always visible on an output port.

The enable sources are produced elsewhere. Every register write lands in one clock cycle.

Top module: `mode_timer16`

## Requirements
- R1: After reset the counter reads 0 and the interrupt flag is 0. The timer is stopped, the output is active-low and push-pull, and the pin is driven high with its enable at 1.
- R2: Control word layout:
  - bit 0: run
  - bits 2:1: mode (00 single pulse, 01 rate generator, 10 square wave, 11 retriggerable one-shot)
  - bit 3: polarity (1 = active high)
  - bit 4: open drain
  - bits 7:5: source select

  Writing run=1 while stopped copies the reload register into the counter and clears the prescaler. The output then starts active in modes 00 and 10, and inactive in modes 01 and 11.
- R3: While running, the counter decrements by one on each tick. A tick occurs every PRESC_DIV-th cycle in which the selected source enable is high.
- R4: Single pulse: the output stays active until the counter reaches zero. The counter then holds at 0 with the output inactive, so the pulse lasts as many ticks as the reload value.
- R5: Rate generator: when the count would reach zero, the counter reloads. The output goes active for exactly one tick period, so the pulse repeats every reload-value ticks.
- R6: Square wave: when the count would reach zero, the counter reloads and the output inverts. The output therefore toggles every reload-value ticks.
- R7: Retriggerable one-shot: a rising edge on the trigger input while running reloads the counter and makes the output active. The pulse ends at zero, a full reload count after the last edge. In the other modes the trigger input has no effect.
- R8: Each time the counter reaches zero the interrupt flag is set. A clear pulse resets it, and a new zero in the same cycle wins over the clear.
- R9: Writing run=0 stops the timer. While stopped the counter holds its value and the output sits at its inactive level.
- R10: The pin level is the active state XOR'ed with inverted polarity. In open-drain mode the pin value is always 0 and the enable is 1 only when the level is low. In push-pull mode the enable is always 1.
- R11: Only the source enable named by the select field advances the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_en | input | 8 | Eight candidate count-enable sources |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 8 | Control word |
| reload_we | input | 1 | Reload register write strobe |
| reload_wdata | input | 16 | Reload value |
| irq_clr | input | 1 | Interrupt flag clear pulse |
| trig_in | input | 1 | External trigger for the one-shot mode |
| pin_val | output | 1 | Output pin value |
| pin_oe | output | 1 | Output pin drive enable |
| irq | output | 1 | Sticky interrupt flag |
| cnt_val | output | 16 | Current counter value |

## Verification
The in-line assertions check these on every cycle:
- the counter steps down by exactly one on each counting tick;
- a count of one turns into a set flag;
- the flag stays set until it is cleared;
- a stopped counter does not move, and its output is idle;
- the open-drain pin never drives high.

Some behaviours only the bench scenarios can show. These are the pulse widths and periods in each mode, the extension of a one-shot by a later trigger, trigger immunity outside that mode, and the effect of the source select on tick rate. The bench checks them against its cycle model and with direct edge counts.

// File: rtl/mode_timer16.sv
module mode_timer16 #(
  parameter int W         = 16,
  parameter int NSRC      = 8,
  parameter int PRESC_DIV = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_en,
  input  logic            ctrl_we,
  input  logic [7:0]      ctrl_wdata,
  input  logic            reload_we,
  input  logic [W-1:0]    reload_wdata,
  input  logic            irq_clr,
  input  logic            trig_in,
  output logic            pin_val,
  output logic            pin_oe,
  output logic            irq,
  output logic [W-1:0]    cnt_val
);
  localparam int SW = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int PW = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;
  localparam logic [PW-1:0] PC_LAST = PW'(PRESC_DIV - 1);
  localparam logic [1:0] M_ONE = 2'd0, M_RATE = 2'd1, M_SQ = 2'd2, M_RTRG = 2'd3;

  logic          run_q, pol_q, od_q, active_q, irq_q, trig_q;
  logic [1:0]    mode_q;
  logic [SW-1:0] sel_q;
  logic [W-1:0]  reload_q, cnt_q;
  logic [PW-1:0] pc_q;

  wire [1:0] wmode    = ctrl_wdata[2:1];
  wire start          = ctrl_we & ctrl_wdata[0] & ~run_q;
  wire stop_now       = ctrl_we & ~ctrl_wdata[0];
  wire busy           = run_q & ~stop_now;
  wire sel_en         = src_en[sel_q];
  wire tick           = busy & sel_en & (pc_q == PC_LAST);
  wire trig_go        = busy & (mode_q == M_RTRG) & trig_in & ~trig_q;
  wire counting       = (mode_q == M_RATE) | (mode_q == M_SQ) | active_q;
  wire hit            = tick & counting & ~trig_go & (cnt_q == W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0; mode_q <= M_ONE; pol_q <= 1'b0; od_q <= 1'b0; sel_q <= '0;
      reload_q <= '0; cnt_q <= '0; pc_q <= '0;
      active_q <= 1'b0; irq_q <= 1'b0; trig_q <= 1'b0;
    end else begin
      trig_q <= trig_in;
      if (reload_we) reload_q <= reload_wdata;
      if (ctrl_we) begin
        run_q  <= ctrl_wdata[0];
        mode_q <= wmode;
        pol_q  <= ctrl_wdata[3];
        od_q   <= ctrl_wdata[4];
        sel_q  <= ctrl_wdata[5 +: SW];
      end
      if (hit) irq_q <= 1'b1;
      else if (irq_clr) irq_q <= 1'b0;

      if (start) begin
        cnt_q    <= reload_q;
        pc_q     <= '0;
        active_q <= (wmode == M_ONE) | (wmode == M_SQ);
      end else if (!busy) begin
        active_q <= 1'b0;
      end else begin
        if (sel_en) pc_q <= (pc_q == PC_LAST) ? '0 : pc_q + 1'b1;
        if (trig_go) begin
          cnt_q    <= reload_q;
          active_q <= 1'b1;
        end else if (tick && counting) begin
          if (cnt_q == W'(1)) begin
            case (mode_q)
              M_RATE:  begin cnt_q <= reload_q; active_q <= 1'b1; end
              M_SQ:    begin cnt_q <= reload_q; active_q <= ~active_q; end
              default: begin cnt_q <= '0; active_q <= 1'b0; end
            endcase
          end else begin
            cnt_q <= cnt_q - 1'b1;
            if (mode_q == M_RATE) active_q <= 1'b0;
          end
        end
      end
    end
  end

  wire lvl = pol_q ? active_q : ~active_q;
  assign pin_val = od_q ? 1'b0 : lvl;
  assign pin_oe  = od_q ? ~lvl : 1'b1;
  assign irq     = irq_q;
  assign cnt_val = cnt_q;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && counting && !trig_go && !ctrl_we && cnt_q > W'(1)) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R3
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && counting && !trig_go && cnt_q == W'(1)) |=> irq); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq); // R8
  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !ctrl_we) |=> $stable(cnt_q)); // R9
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !active_q); // R9
  AST_OD_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    od_q |-> !(pin_oe && pin_val)); // R10
endmodule

// File: tb/mode_timer16_bench.sv
module mode_timer16_bench;
  localparam int CLK_PERIOD = 10;
  localparam int P = 4;

  logic clk = 0, rst_n = 0;
  logic [7:0] src_en = '0;
  logic ctrl_we = 0, reload_we = 0, irq_clr = 0, trig_in = 0;
  logic [7:0] ctrl_wdata = '0;
  logic [15:0] reload_wdata = '0;
  logic pin_val, pin_oe, irq;
  logic [15:0] cnt_val;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  mode_timer16 #(.W(16), .NSRC(8), .PRESC_DIV(P)) u_mode_timer16 (
    .clk, .rst_n, .src_en, .ctrl_we, .ctrl_wdata, .reload_we, .reload_wdata,
    .irq_clr, .trig_in, .pin_val, .pin_oe, .irq, .cnt_val);

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model state
  int m_run, m_mode, m_pol, m_od, m_sel, m_reload, m_cnt, m_pc, m_act, m_irq, m_trigp;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_mode = 0; m_pol = 0; m_od = 0; m_sel = 0; m_reload = 0;
      m_cnt = 0; m_pc = 0; m_act = 0; m_irq = 0; m_trigp = 0;
    end else begin
      bit st, sp, sen, tk, tg, cin;
      int nmode, nirq;
      nmode = ctrl_wdata[2:1];
      st  = ctrl_we && ctrl_wdata[0] && m_run == 0;
      sp  = ctrl_we && !ctrl_wdata[0];
      sen = src_en[m_sel];
      tk  = m_run && !sp && sen && m_pc == P-1;
      tg  = m_run && !sp && m_mode == 3 && trig_in && !m_trigp;
      cin = m_mode == 1 || m_mode == 2 || m_act;
      nirq = irq_clr ? 0 : m_irq;
      if (st) begin
        m_cnt = m_reload; m_pc = 0; m_act = (nmode == 0 || nmode == 2);
      end else if (!m_run || sp) m_act = 0;
      else begin
        if (sen) m_pc = (m_pc + 1) % P;
        if (tg) begin m_cnt = m_reload; m_act = 1; end
        else if (tk && cin) begin
          if (m_cnt == 1) begin
            nirq = 1;
            if (m_mode == 1) begin m_cnt = m_reload; m_act = 1; end
            else if (m_mode == 2) begin m_cnt = m_reload; m_act = !m_act; end
            else begin m_cnt = 0; m_act = 0; end
          end else begin
            m_cnt = (m_cnt - 1) & 16'hFFFF;
            if (m_mode == 1) m_act = 0;
          end
        end
      end
      if (ctrl_we) begin
        m_run = ctrl_wdata[0]; m_mode = nmode; m_pol = ctrl_wdata[3];
        m_od = ctrl_wdata[4]; m_sel = ctrl_wdata[7:5];
      end
      if (reload_we) m_reload = reload_wdata;
      m_irq = nirq; m_trigp = trig_in;
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // source enables and per-cycle comparison
  always @(negedge clk) begin
    cyc++;
    for (int k = 0; k < 8; k++) src_en[k] = (cyc % (k + 1)) == 0;
    if (rst_n && !done) begin
      int lvl;
      lvl = m_pol ? m_act : !m_act;
      chk(cnt_val, m_cnt, "R3 counter");
      chk(irq, m_irq, "R8 flag");
      chk(pin_val, m_od ? 0 : lvl, "R10 pin value");
      chk(pin_oe, m_od ? !lvl : 1, "R10 pin enable");
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wr_ctrl(input logic [7:0] v);
    @(negedge clk); ctrl_we = 1; ctrl_wdata = v;
    @(negedge clk); ctrl_we = 0;
  endtask
  task automatic wr_reload(input logic [15:0] v);
    @(negedge clk); reload_we = 1; reload_wdata = v;
    @(negedge clk); reload_we = 0;
  endtask
  task automatic pulse_trig();
    @(negedge clk); trig_in = 1;
    @(negedge clk); trig_in = 0;
  endtask
  task automatic count_rises(input int n, output int r);
    int prev;
    r = 0; prev = pin_val;
    repeat (n) begin
      @(negedge clk); #1;
      if (pin_val && !prev) r++;
      prev = pin_val;
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int r, held;
    cycles(3); rst_n = 1; #1;
    chk(cnt_val, 0, "R1 reset count"); chk(irq, 0, "R1 reset flag");
    chk(pin_val, 1, "R1 reset pin"); chk(pin_oe, 1, "R1 reset enable");

    // single pulse, active high
    wr_reload(5); wr_ctrl(8'h09); #1;
    chk(cnt_val, 5, "R2 load on start"); chk(pin_val, 1, "R4 pulse active");
    cycles(25); #1;
    chk(pin_val, 0, "R4 pulse ended"); chk(cnt_val, 0, "R4 holds zero");
    chk(irq, 1, "R8 flag set at zero");
    @(negedge clk); irq_clr = 1; @(negedge clk); irq_clr = 0; #1;
    chk(irq, 0, "R8 flag cleared");
    pulse_trig(); cycles(2); #1;
    chk(pin_val, 0, "R7 trigger ignored in single mode");
    chk(cnt_val, 0, "R7 trigger leaves count");
    wr_ctrl(8'h08);

    // rate generator: reload 3 -> pulse every 12 cycles
    wr_reload(3); wr_ctrl(8'h0B); cycles(5);
    count_rises(48, r); chk(r, 4, "R5 rate pulses in 48 cycles");
    // stop while running
    wr_reload(100); wr_ctrl(8'h0A); wr_ctrl(8'h0B); cycles(30);
    wr_ctrl(8'h0A); #1; held = cnt_val;
    cycles(30); #1;
    chk(cnt_val, held, "R9 count held while stopped"); chk(pin_val, 0, "R9 output inactive");

    // square wave: reload 2 -> toggle every 8 cycles
    wr_reload(2); wr_ctrl(8'h0D); cycles(3);
    count_rises(64, r); chk(r, 4, "R6 square rises in 64 cycles");
    wr_ctrl(8'h0C);

    // source select 7: one enable in 8 cycles
    wr_reload(3); wr_ctrl(8'hED); cycles(20); #1;
    chk(cnt_val, 3, "R11 slow source no tick yet");
    cycles(60); wr_ctrl(8'hEC);

    // retriggerable one-shot: reload 4 -> 16 cycles
    wr_reload(4); wr_ctrl(8'h0F); cycles(4); #1;
    chk(pin_val, 0, "R7 armed, inactive");
    pulse_trig(); cycles(10); pulse_trig(); cycles(10); #1;
    chk(pin_val, 1, "R7 retrigger extends pulse");
    cycles(15); #1;
    chk(pin_val, 0, "R7 pulse ended after last trigger");
    wr_ctrl(8'h0E);

    // active-low open drain single pulse
    wr_reload(3); wr_ctrl(8'h11); #1;
    chk(pin_val, 0, "R10 od drives low"); chk(pin_oe, 1, "R10 od enabled while active");
    cycles(20); #1;
    chk(pin_oe, 0, "R10 od released when inactive");
    wr_ctrl(8'h10); cycles(4);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule